// File: doc/BRIEF.md
# SDRAM Command Sequencer with Scheduled Refresh

This block sits between a simple request port and a four-bank single-data-rate SDRAM. After reset it brings the memory up by itself: a long NOP wait, a precharge of every bank, two auto-refresh commands and a mode-register load. It then accepts one read or write at a time. Each access opens the addressed row, issues the column command and closes the bank again, so no row is ever left open between requests.

A free-running interval counter raises a refresh request. That request is served at the next idle point and always wins over a waiting user request. The request port holds `req_ready` low while a refresh is pending or running. Read data is taken from the data bus after the column-strobe latency selected by `cas3_sel`, which is two or three clocks. The bus value one clock earlier is never taken.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low, the command pins deselect the device (`sd_cs_n`=1), and `req_ready`, `rd_valid` and `sd_dq_oe` are all 0.
- R2: After reset, the pins carry only NOP for at least INIT_WAIT clocks. Then a precharge with `sd_addr[10]`=1 is issued, then exactly two refreshes, then a mode load. No ACTIVE appears before the mode load.
- R3: The mode load drives bank 0. `sd_addr[6:4]` holds the latency (3'd3 when `cas3_sel`=1, else 3'd2). All other `sd_addr` bits are 0, which selects burst length 1, sequential order, normal operating mode (bits 8:7 = 00) and bursting writes.
- R4: A write stores `req_wdata` at the requested location. A later read of that location returns the same value on `rd_data` with a one-cycle `rd_valid` pulse. Reads complete in request order.
- R5: For a READ registered by the device at edge n, `rd_data` is taken at edge n+m (m=3 if `cas3_sel` else 2). The bus value present at edge n+m-1 is not used.
- R6: The gap from a command to the next non-NOP command is at least T_RCD after ACTIVE, T_WR after READ/WRITE, T_RP after PRECHARGE, T_RFC after REFRESH and T_MRD after a mode load.
- R7: Each access issues ACTIVE, then one READ or WRITE with `sd_addr[10]`=0, then a PRECHARGE to the same bank with `sd_addr[10]`=0. Every bank is closed when a REFRESH is issued.
- R8: After initialization, refresh commands keep coming with no user traffic. The gap between two consecutive refreshes never exceeds REF_INTERVAL+16 clocks.
- R9: A pending refresh is issued before any new ACTIVE. `req_ready` is 0 in every cycle in which REFRESH is on the pins.
- R10: `sd_dq_oe` is 1 only in the cycle that carries a WRITE. In that cycle `sd_dq_out` equals the request's data and `sd_dqm` is all zeros.
- R11: `req_addr` is split as {bank, row, column}: column in bits [COL_W-1:0], row in the next ROW_W bits and bank in the top BA_W bits. These values appear on `sd_ba`/`sd_addr` at ACTIVE (row) and READ/WRITE (column).
- R12: Commands are encoded on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} as NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, mode load 0000, deselect 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the device |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas3_sel | input | 1 | 1 selects latency 3, 0 selects latency 2; held stable after reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | BA_W+ROW_W+COL_W | Bank, row and column |
| req_wdata | input | DQ_W | Write data |
| req_ready | output | 1 | Request is taken at this edge when valid |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DQ_W | Captured read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_dqm | output | DQ_W/8 | Byte masks |
| sd_dq_out | output | DQ_W | Data driven to the device |
| sd_dq_oe | output | 1 | Drive enable for `sd_dq_out` |
| sd_dq_in | input | DQ_W | Data returned by the device |

## Verification
The bench's memory model drives a poison word on the data bus outside the single valid window. A capture that runs one clock early (the n+m-1 edge) or uses the wrong latency setting would therefore return poison instead of the stored word. Each run uses both latency settings.

Per-command spacing is measured against the preceding command's kind. A counter that reloads one short would place a command too early. Refresh gaps are measured both under heavy back-to-back traffic and with no traffic. A refresh that did not preempt a queued request, or a dropped timer expiry, would stretch a gap beyond the bound.

Distinct banks, all-ones rows and columns, and an overwrite of the same location test the address split and the ordering of write data.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WRITE = 4'b0100,
    CMD_READ  = 4'b0101,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sdc_cmd_e;

  typedef enum logic [3:0] {
    S_PWR, S_WAIT, S_IREF1, S_IREF2, S_MRS, S_IDLE, S_COL, S_PRE
  } sdc_state_e;

  // Burst length 1, sequential, latency field, normal mode, bursting writes.
  function automatic logic [9:0] mode_word(input logic cas3);
    logic [9:0] w;
    w = '0;
    w[6:4] = cas3 ? 3'd3 : 3'd2;
    return w;
  endfunction

endpackage

// File: rtl/sdc_refresh_timer.sv
module sdc_refresh_timer #(
  parameter int INTERVAL = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pending
);
  localparam int W = $clog2(INTERVAL + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         pend_d;

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pending;
    if (ack) pend_d = 1'b0;
    if (en) begin
      if (cnt_q == '0) begin
        cnt_d  = W'(INTERVAL - 1);
        pend_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= W'(INTERVAL - 1);
      pending <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pending <= pend_d;
    end
  end

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !ack |=> pending);

  // R8
  expiry_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && cnt_q == '0 |=> pending);

endmodule

// File: rtl/sdc_read_capture.sv
module sdc_read_capture #(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cas3,
  input  logic            rd_issue,
  input  logic [DQ_W-1:0] dq_in,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data
);
  localparam int DEPTH = 3;

  logic [DEPTH-1:0] pipe_q, pipe_d;
  logic             take;
  logic [DQ_W-1:0]  data_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], rd_issue};
    take   = cas3 ? pipe_q[2] : pipe_q[1];
    data_d = take ? dq_in : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe_q   <= pipe_d;
      rd_valid <= take;
      rd_data  <= data_d;
    end
  end

  // R5
  cl2_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue && !cas3 |-> ##3 rd_valid);

  // R5
  cl3_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue && cas3 |-> ##4 rd_valid);

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl #(
  parameter int BA_W         = 2,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,   // must stay below 10 + 1 so A10 is free
  parameter int DQ_W         = 16,
  parameter int INIT_WAIT    = 16700,
  parameter int REF_INTERVAL = 1250,
  parameter int T_RP         = 3,
  parameter int T_RCD        = 3,
  parameter int T_RFC        = 10,
  parameter int T_MRD        = 2,
  parameter int T_WR         = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cas3_sel,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [BA_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]               req_wdata,
  output logic                          req_ready,
  output logic                          rd_valid,
  output logic [DQ_W-1:0]               rd_data,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BA_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [DQ_W/8-1:0]             sd_dqm,
  output logic [DQ_W-1:0]               sd_dq_out,
  output logic                          sd_dq_oe,
  input  logic [DQ_W-1:0]               sd_dq_in
);
  import sdc_pkg::*;

  localparam int DM_W  = DQ_W / 8;
  localparam int CNT_W = $clog2(INIT_WAIT + T_RP + T_RCD + T_RFC + T_MRD + T_WR + 1);

  sdc_state_e           state_q, state_d, ret_q, ret_d;
  logic [CNT_W-1:0]     wcnt_q, wcnt_d;
  sdc_cmd_e             cmd_q, cmd_d;
  logic [BA_W-1:0]      ba_q, ba_d;
  logic [ROW_W-1:0]     addr_q, addr_d;
  logic [DM_W-1:0]      dqm_q, dqm_d;
  logic [DQ_W-1:0]      dqo_q, dqo_d;
  logic                 oe_q, oe_d;
  logic                 done_q, done_d;
  logic                 lat_we_q, lat_we_d;
  logic [BA_W-1:0]      lat_ba_q, lat_ba_d;
  logic [COL_W-1:0]     lat_col_q, lat_col_d;
  logic [DQ_W-1:0]      lat_wd_q, lat_wd_d;
  logic                 ref_pending, ref_ack;

  sdc_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(done_q), .ack(ref_ack), .pending(ref_pending)
  );

  sdc_read_capture #(.DQ_W(DQ_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cas3(cas3_sel), .rd_issue(cmd_q == CMD_READ),
    .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign req_ready = (state_q == S_IDLE) && !ref_pending;

  always_comb begin
    state_d   = state_q;
    ret_d     = ret_q;
    wcnt_d    = wcnt_q;
    cmd_d     = CMD_NOP;
    ba_d      = ba_q;
    addr_d    = addr_q;
    dqm_d     = {DM_W{1'b1}};
    dqo_d     = dqo_q;
    oe_d      = 1'b0;
    done_d    = done_q;
    lat_we_d  = lat_we_q;
    lat_ba_d  = lat_ba_q;
    lat_col_d = lat_col_q;
    lat_wd_d  = lat_wd_q;
    ref_ack   = 1'b0;
    unique case (state_q)
      S_PWR: begin
        if (wcnt_q == '0) begin
          cmd_d      = CMD_PRE;
          addr_d     = '0;
          addr_d[10] = 1'b1;
          wcnt_d     = CNT_W'(T_RP - 1);
          ret_d      = S_IREF1;
          state_d    = S_WAIT;
        end else begin
          wcnt_d = wcnt_q - 1'b1;
        end
      end
      S_WAIT: begin
        if (wcnt_q == '0) state_d = ret_q;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      S_IREF1, S_IREF2: begin
        cmd_d   = CMD_REF;
        wcnt_d  = CNT_W'(T_RFC - 1);
        ret_d   = (state_q == S_IREF1) ? S_IREF2 : S_MRS;
        state_d = S_WAIT;
      end
      S_MRS: begin
        cmd_d       = CMD_MRS;
        ba_d        = '0;
        addr_d      = '0;
        addr_d[9:0] = mode_word(cas3_sel);
        wcnt_d      = CNT_W'(T_MRD - 1);
        ret_d       = S_IDLE;
        done_d      = 1'b1;
        state_d     = S_WAIT;
      end
      S_IDLE: begin
        if (ref_pending) begin
          cmd_d   = CMD_REF;
          ref_ack = 1'b1;
          wcnt_d  = CNT_W'(T_RFC - 1);
          ret_d   = S_IDLE;
          state_d = S_WAIT;
        end else if (req_valid) begin
          cmd_d     = CMD_ACT;
          ba_d      = req_addr[COL_W+ROW_W +: BA_W];
          addr_d    = req_addr[COL_W +: ROW_W];
          lat_we_d  = req_write;
          lat_ba_d  = req_addr[COL_W+ROW_W +: BA_W];
          lat_col_d = req_addr[COL_W-1:0];
          lat_wd_d  = req_wdata;
          wcnt_d    = CNT_W'(T_RCD - 1);
          ret_d     = S_COL;
          state_d   = S_WAIT;
        end
      end
      S_COL: begin
        cmd_d              = lat_we_q ? CMD_WRITE : CMD_READ;
        ba_d               = lat_ba_q;
        addr_d             = '0;
        addr_d[COL_W-1:0]  = lat_col_q;
        dqm_d              = '0;
        oe_d               = lat_we_q;
        dqo_d              = lat_wd_q;
        wcnt_d             = CNT_W'(T_WR - 1);
        ret_d              = S_PRE;
        state_d            = S_WAIT;
      end
      S_PRE: begin
        cmd_d   = CMD_PRE;
        ba_d    = lat_ba_q;
        addr_d  = '0;
        wcnt_d  = CNT_W'(T_RP - 1);
        ret_d   = S_IDLE;
        state_d = S_WAIT;
      end
      default: state_d = S_PWR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_PWR;
      ret_q     <= S_PWR;
      wcnt_q    <= CNT_W'(INIT_WAIT - 1);
      cmd_q     <= CMD_DESEL;
      ba_q      <= '0;
      addr_q    <= '0;
      dqm_q     <= {DM_W{1'b1}};
      dqo_q     <= '0;
      oe_q      <= 1'b0;
      done_q    <= 1'b0;
      lat_we_q  <= 1'b0;
      lat_ba_q  <= '0;
      lat_col_q <= '0;
      lat_wd_q  <= '0;
    end else begin
      state_q   <= state_d;
      ret_q     <= ret_d;
      wcnt_q    <= wcnt_d;
      cmd_q     <= cmd_d;
      ba_q      <= ba_d;
      addr_q    <= addr_d;
      dqm_q     <= dqm_d;
      dqo_q     <= dqo_d;
      oe_q      <= oe_d;
      done_q    <= done_d;
      lat_we_q  <= lat_we_d;
      lat_ba_q  <= lat_ba_d;
      lat_col_q <= lat_col_d;
      lat_wd_q  <= lat_wd_d;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dqm    = dqm_q;
  assign sd_dq_out = dqo_q;
  assign sd_dq_oe  = oe_q;

  // R9
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_IDLE && ref_pending |=> cmd_q == CMD_REF);

  // R6
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q == CMD_ACT |=> cmd_q == CMD_NOP);

  // R10
  oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> cmd_q == CMD_WRITE && dqm_q == '0);

  // R2
  no_early_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> cmd_q != CMD_ACT && !req_ready);

endmodule

// File: tb/sdram_cmd_ctrl_test.sv
module sdram_cmd_ctrl_test;
  localparam int CLK_P   = 10;
  localparam int IW      = 40;
  localparam int RI      = 150;
  localparam int TRP     = 2;
  localparam int TRCD    = 2;
  localparam int TRFC    = 4;
  localparam int TMRD    = 2;
  localparam int TWR     = 2;
  localparam logic [15:0] POISON = 16'hDEAD;

  logic        clk = 1'b0;
  logic        rst_n, cas3_sel, req_valid, req_write, req_ready, rd_valid;
  logic [24:0] req_addr;
  logic [15:0] req_wdata, rd_data, sd_dq_out, sd_dq_in;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0]  sd_ba, sd_dqm;
  logic [12:0] sd_addr;

  sdram_cmd_ctrl #(.INIT_WAIT(IW), .REF_INTERVAL(RI), .T_RP(TRP), .T_RCD(TRCD),
                   .T_RFC(TRFC), .T_MRD(TMRD), .T_WR(TWR)) uut (
    .clk(clk), .rst_n(rst_n), .cas3_sel(cas3_sel), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  logic [15:0] gold [bit [24:0]];
  logic [15:0] dev_mem [bit [24:0]];
  int          reads_out = 0, reads_in = 0;
  logic [24:0] cur_addr;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // device-side model state
  int        cyc, last_cyc, ref_cnt, iref_n, last_ref;
  bit        pre_all_seen, mrs_seen;
  logic [3:0] last_cmd;
  bit  [3:0] open_b;
  logic [12:0] open_row [4];

  function automatic int need_gap(input logic [3:0] c);
    case (c)
      4'b0011: return TRCD;
      4'b0100, 4'b0101: return TWR;
      4'b0010: return TRP;
      4'b0001: return TRFC;
      4'b0000: return TMRD;
      default: return 0;
    endcase
  endfunction

  task automatic drive_read(input logic [15:0] d, input int m);
    repeat (m) @(negedge clk);
    sd_dq_in = d;
    @(negedge clk);
    sd_dq_in = POISON;
  endtask

  always @(negedge clk) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (!rst_n) begin
      cyc = 0; last_cyc = -1000; ref_cnt = 0; iref_n = 0; last_ref = 0;
      pre_all_seen = 0; mrs_seen = 0; last_cmd = 4'b0111; open_b = '0;
    end else begin
      cyc++;
      if (c != 4'b0111 && c != 4'b1111) begin
        // R6 spacing from previous command
        chk(cyc - last_cyc >= need_gap(last_cmd), "R6", cyc - last_cyc, need_gap(last_cmd));
        last_cmd = c; last_cyc = cyc;
      end
      if (c != 4'b0100) chk(sd_dq_oe == 1'b0, "R10", sd_dq_oe, 0);
      case (c)
        4'b0010: begin
          if (!pre_all_seen) begin
            chk(cyc >= IW, "R2", cyc, IW);
            chk(sd_addr[10] == 1'b1, "R2", sd_addr[10], 1);
            pre_all_seen = 1;
          end else begin
            chk(sd_addr[10] == 1'b0 && open_b[sd_ba], "R7", {sd_addr[10], open_b[sd_ba]}, 2'b01);
            open_b[sd_ba] = 1'b0;
          end
        end
        4'b0001: begin
          chk(pre_all_seen && open_b == '0, "R7", open_b, 0);
          chk(req_ready == 1'b0, "R9", req_ready, 0);
          if (!mrs_seen) iref_n++;
          else begin
            chk(cyc - last_ref <= RI + 16, "R8", cyc - last_ref, RI + 16);
            ref_cnt++;
          end
          last_ref = cyc;
        end
        4'b0000: begin
          chk(iref_n == 2, "R2", iref_n, 2);
          chk({sd_ba, sd_addr} == {2'b00, 6'b0, (cas3_sel ? 3'd3 : 3'd2), 4'b0},
              "R3", {sd_ba, sd_addr}, {2'b00, 6'b0, (cas3_sel ? 3'd3 : 3'd2), 4'b0});
          mrs_seen = 1;
        end
        4'b0011: begin
          chk(mrs_seen && !open_b[sd_ba], "R7", {mrs_seen, open_b[sd_ba]}, 2'b10);
          chk({sd_ba, sd_addr} == cur_addr[24:10], "R11", {sd_ba, sd_addr}, cur_addr[24:10]);
          open_b[sd_ba] = 1'b1; open_row[sd_ba] = sd_addr;
        end
        4'b0100, 4'b0101: begin
          chk(open_b[sd_ba] && sd_addr[10] == 1'b0, "R7", {open_b[sd_ba], sd_addr[10]}, 2'b10);
          chk({sd_ba, sd_addr[9:0]} == {cur_addr[24:23], cur_addr[9:0]}, "R11",
              {sd_ba, sd_addr[9:0]}, {cur_addr[24:23], cur_addr[9:0]});
          chk(sd_dqm == 2'b00, "R10", sd_dqm, 0);
          if (c == 4'b0100) begin
            chk(sd_dq_oe == 1'b1, "R10", sd_dq_oe, 1);
            dev_mem[{sd_ba, open_row[sd_ba], sd_addr[9:0]}] = sd_dq_out;
          end else begin
            automatic logic [15:0] d = dev_mem.exists({sd_ba, open_row[sd_ba], sd_addr[9:0]}) ?
                                       dev_mem[{sd_ba, open_row[sd_ba], sd_addr[9:0]}] : 16'h0;
            automatic int m = cas3_sel ? 3 : 2;
            fork drive_read(d, m); join_none
          end
        end
        4'b0111, 4'b1111: ;
        default: chk(1'b0, "R12", c, 4'b0111);
      endcase
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      reads_in++;
      if (exp_q.size() == 0) chk(1'b0, "R4", rd_data, 16'hFFFF);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        chk(rd_data == e, cas3_sel ? "R4 R5 latency3" : "R4 R5 latency2", rd_data, e);
      end
    end
  end

  task automatic do_req(input bit we, input logic [24:0] a, input logic [15:0] d);
    while (!req_ready) @(negedge clk);
    cur_addr  = a;
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    if (we) gold[a] = d;
    else begin
      exp_q.push_back(gold.exists(a) ? gold[a] : 16'h0);
      reads_out++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_phase(input bit cl3);
    int r0;
    rst_n = 1'b0; cas3_sel = cl3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sd_cs_n == 1'b1 && req_ready == 1'b0 && rd_valid == 1'b0 && sd_dq_oe == 1'b0, "R1",
        {sd_cs_n, req_ready, rd_valid, sd_dq_oe}, 4'b1000);
    rst_n = 1'b1;
    while (!mrs_seen) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      automatic logic [24:0] a = {2'(i), 13'(i * 977 + (i == 7 ? 13'h1FFF : 0)),
                                  10'((i * 131) | (i == 7 ? 10'h3FF : 0))};
      do_req(1'b1, a, 16'hA500 ^ 16'(i) ^ {7'b0, cl3, 8'b0});
    end
    for (int i = 7; i >= 0; i--) begin
      automatic logic [24:0] a = {2'(i), 13'(i * 977 + (i == 7 ? 13'h1FFF : 0)),
                                  10'((i * 131) | (i == 7 ? 10'h3FF : 0))};
      do_req(1'b0, a, '0);
    end
    // overwrite the same location then read it (R4)
    do_req(1'b1, 25'h0, 16'h1111);
    do_req(1'b1, 25'h0, 16'h2222);
    do_req(1'b0, 25'h0, '0);
    // sustained traffic across several refresh periods (R8, R9)
    for (int i = 0; i < 60; i++) begin
      automatic logic [24:0] a = {2'(i % 4), 13'(i * 37), 10'(i * 3)};
      do_req(1'b1, a, 16'(i * 4099 + 7));
      do_req(1'b0, a, '0);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(reads_in == reads_out, "R4", reads_in, reads_out);
    // idle window: refresh must continue without traffic (R8)
    r0 = ref_cnt;
    repeat (3 * RI) @(negedge clk);
    chk(ref_cnt - r0 >= 2, "R8", ref_cnt - r0, 2);
  endtask

  initial begin
    rst_n = 1'b0; cas3_sel = 1'b1; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; sd_dq_in = POISON; cur_addr = '0;
    run_phase(1'b1);
    reads_in = 0; reads_out = 0;
    run_phase(1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule